// File: doc/BRIEF.md
# Ring-Buffer Destination Address Wrapper

This block sits on the destination-address path of a memory-to-memory DMA channel. It holds the current write address and, after each burst, advances it by the burst length in quadwords (16 bytes each). A two-bit mode field picks how the advanced address is treated. Modes 0 and 1 give plain linear addressing. Modes 2 and 3 confine the address to a power-of-two ring region, described by a base register and a size mask.

In ring mode the block also does two more things. It raises a warning when a burst starts from an address outside the ring. It adds up the quadwords written, and when the transfer completes it hands that total to the consumer channel that the mode selects: mode 3 selects the graphics consumer and mode 2 selects the vector consumer. The hand-off is a one-cycle pulse with the count on a shared bus, and the total restarts from zero. The ring mask is expected to have the form 2^n-1 with n of at least 4, so that wrapping keeps quadword alignment.

Top module: `ring_dst_wrapper`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `dst_addr` is 0, `ring_warn` is 0, `gfx_take` and `vec_take` are 0, `take_count` is 0, and the quadword total is 0.
- R2: In linear mode (`ring_mode` 0 or 1), an accepted burst sets `dst_addr` to the previous address plus `burst_qwc`*16, with no wrapping.
- R3: In ring mode (`ring_mode` 2 or 3), an accepted burst sets `dst_addr` to `ring_base` + ((previous address + `burst_qwc`*16) AND `ring_mask`).
- R4: On each accepted burst, `ring_warn` becomes 1 if ring mode is on and (previous address AND NOT `ring_mask`) differs from `ring_base`; otherwise it becomes 0. Between bursts it holds its value.
- R5: The quadword total grows by `burst_qwc` on each accepted burst in ring mode. Bursts in linear mode leave it unchanged.
- R6: When `xfer_done` is high in ring mode, exactly one take line pulses high for one cycle, in the next cycle: `gfx_take` for mode 3 and `vec_take` for mode 2. `take_count` carries the total, including any burst accepted in that same cycle. The total then restarts from 0.
- R7: `xfer_done` in linear mode produces no pulse and leaves the total unchanged. `take_count` is 0 in every cycle with no pulse.
- R8: `load_en` loads `load_addr` into `dst_addr` unchanged, in the next cycle. A burst presented in the same cycle is dropped entirely: it changes neither the address, the warning nor the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_mode | input | 2 | Addressing mode: 0/1 linear, 2 ring to vector consumer, 3 ring to graphics consumer |
| ring_base | input | 32 | Byte base address of the ring |
| ring_mask | input | 32 | Ring offset mask (2^n-1) |
| load_en | input | 1 | Load a new destination address |
| load_addr | input | 32 | Address loaded by `load_en` |
| burst_en | input | 1 | A burst is written from the current address |
| burst_qwc | input | 16 | Burst length in quadwords |
| xfer_done | input | 1 | Transfer complete; hand the total over |
| dst_addr | output | 32 | Current (wrapped) destination address |
| ring_warn | output | 1 | Last burst started outside the ring |
| gfx_take | output | 1 | One-cycle hand-off to the graphics consumer |
| vec_take | output | 1 | One-cycle hand-off to the vector consumer |
| take_count | output | 32 | Quadword total during a hand-off pulse, else 0 |

## Verification
Every result is registered once. The address, the warning and the hand-off pulse with its count all appear in the cycle after the edge that accepted the load, burst or completion. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. For the hand-off it also samples one cycle later, to confirm that the pulse lasted a single cycle. Input combinations that have no effect are checked through the values that follow on `dst_addr`, `ring_warn` and `take_count`.

// File: rtl/rdw_pkg.sv
package rdw_pkg;

    typedef enum logic [1:0] {
        MODE_LINEAR_A = 2'd0,
        MODE_LINEAR_B = 2'd1,
        MODE_RING_VEC = 2'd2,
        MODE_RING_GFX = 2'd3
    } ring_mode_e;

    // consumer slots in the one-hot select
    localparam int CONS_VEC = 0;
    localparam int CONS_GFX = 1;
    localparam int NUM_CONS = 2;

    typedef struct packed {
        logic                ring_on;
        logic [NUM_CONS-1:0] cons_sel;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [1:0] m);
        mode_dec_t d;
        d.ring_on  = 1'b0;
        d.cons_sel = '0;
        case (ring_mode_e'(m))
            MODE_RING_VEC: begin
                d.ring_on = 1'b1;
                d.cons_sel[CONS_VEC] = 1'b1;
            end
            MODE_RING_GFX: begin
                d.ring_on = 1'b1;
                d.cons_sel[CONS_GFX] = 1'b1;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rdw_addr_step.sv
module rdw_addr_step #(
    parameter int AW    = 32,
    parameter int QW    = 16,
    parameter int SHIFT = 4
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [QW-1:0] qwc,
    input  logic          ring_on,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] next_addr,
    output logic          outside
);
    localparam int PAD = AW - QW;

    logic [AW-1:0] byte_len;
    logic [AW-1:0] advanced;

    always_comb begin
        byte_len  = {{PAD{1'b0}}, qwc} << SHIFT;
        advanced  = cur_addr + byte_len;
        outside   = ((cur_addr & ~mask) != base);
        next_addr = ring_on ? (base + (advanced & mask)) : advanced;
    end
endmodule

// File: rtl/rdw_qw_accum.sv
module rdw_qw_accum #(
    parameter int QW    = 16,
    parameter int CW    = 32,
    parameter int NCONS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic [QW-1:0]    add_qwc,
    input  logic             done,
    input  logic             ring_on,
    input  logic [NCONS-1:0] cons_sel,
    output logic [NCONS-1:0] take_v,
    output logic [CW-1:0]    take_cnt
);
    localparam int PAD = CW - QW;

    logic [CW-1:0] total_q;
    logic [CW-1:0] sum;
    logic          fire;

    always_comb begin
        sum  = total_q + (add_en ? {{PAD{1'b0}}, add_qwc} : '0);
        fire = done && ring_on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q  <= '0;
            take_cnt <= '0;
        end else if (fire) begin
            total_q  <= '0;
            take_cnt <= sum;
        end else begin
            total_q  <= sum;
            take_cnt <= '0;
        end
    end

    for (genvar g = 0; g < NCONS; g++) begin : g_take
        always_ff @(posedge clk) begin
            if (rst) take_v[g] <= 1'b0;
            else     take_v[g] <= fire && cons_sel[g];
        end
    end

    // R6
    take_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take_v));

    // R6
    take_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ring_on) |=> (take_v != '0));

    // R7
    quiet_count_chk: assert property (@(posedge clk) disable iff (rst)
        (take_v == '0) |-> (take_cnt == '0));

    // R7
    linear_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !ring_on) |=> (take_v == '0));
endmodule

// File: rtl/ring_dst_wrapper.sv
module ring_dst_wrapper
    import rdw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int QWC_W  = 16,
    parameter int CNT_W  = 32,
    parameter int QW_LOG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ring_mode,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [ADDR_W-1:0] ring_mask,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              burst_en,
    input  logic [QWC_W-1:0]  burst_qwc,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              ring_warn,
    output logic              gfx_take,
    output logic              vec_take,
    output logic [CNT_W-1:0]  take_count
);
    mode_dec_t           dec;
    logic                accept;
    logic [ADDR_W-1:0]   stepped;
    logic                outside;
    logic [NUM_CONS-1:0] take_v;

    always_comb begin
        dec    = decode_mode(ring_mode);
        accept = burst_en && !load_en;
    end

    rdw_addr_step #(.AW(ADDR_W), .QW(QWC_W), .SHIFT(QW_LOG)) step_i (
        .cur_addr (dst_addr),
        .qwc      (burst_qwc),
        .ring_on  (dec.ring_on),
        .base     (ring_base),
        .mask     (ring_mask),
        .next_addr(stepped),
        .outside  (outside)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_addr  <= '0;
            ring_warn <= 1'b0;
        end else if (load_en) begin
            dst_addr  <= load_addr;
        end else if (accept) begin
            dst_addr  <= stepped;
            ring_warn <= dec.ring_on && outside;
        end
    end

    rdw_qw_accum #(.QW(QWC_W), .CW(CNT_W), .NCONS(NUM_CONS)) acc_i (
        .clk     (clk),
        .rst     (rst),
        .add_en  (accept && dec.ring_on),
        .add_qwc (burst_qwc),
        .done    (xfer_done),
        .ring_on (dec.ring_on),
        .cons_sel(dec.cons_sel),
        .take_v  (take_v),
        .take_cnt(take_count)
    );

    always_comb begin
        gfx_take = take_v[CONS_GFX];
        vec_take = take_v[CONS_VEC];
    end

    // R8
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (dst_addr == $past(load_addr)));

    // R4
    linear_warn_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !ring_mode[1]) |=> !ring_warn);

    // R4
    warn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!burst_en || load_en) |=> $stable(ring_warn));

    // R2
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !ring_mode[1]) |=>
        (dst_addr == $past(dst_addr) + ({{(ADDR_W-QWC_W){1'b0}}, $past(burst_qwc)} << QW_LOG)));

    // R3
    ring_inside_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && ring_mode[1]) |=> ((dst_addr & ~$past(ring_mask)) == $past(ring_base)));

    // R6
    gfx_sel_chk: assert property (@(posedge clk) disable iff (rst)
        gfx_take |-> ($past(ring_mode) == 2'd3));
endmodule

// File: tb/ring_dst_wrapper_tb.sv
module ring_dst_wrapper_tb_top;
    localparam int CLK_P = 10;
    localparam logic [31:0] BASE = 32'h0010_0000;
    localparam logic [31:0] MASK = 32'h0000_0FFF;
    localparam int NV = 8;
    // {mode, qwc}
    localparam logic [17:0] VECS [NV] = '{
        {2'd2, 16'd2}, {2'd2, 16'd4}, {2'd3, 16'd1}, {2'd0, 16'd3},
        {2'd1, 16'd5}, {2'd3, 16'd64}, {2'd2, 16'd300}, {2'd3, 16'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ring_mode = 2'd0;
    logic [31:0] ring_base = BASE;
    logic [31:0] ring_mask = MASK;
    logic        load_en = 1'b0;
    logic [31:0] load_addr = '0;
    logic        burst_en = 1'b0;
    logic [15:0] burst_qwc = '0;
    logic        xfer_done = 1'b0;
    logic [31:0] dst_addr;
    logic        ring_warn;
    logic        gfx_take;
    logic        vec_take;
    logic [31:0] take_count;

    int errors = 0;
    int checks = 0;
    bit ended = 1'b0;
    logic [31:0] m_addr;
    logic        m_warn;
    logic [31:0] m_acc;

    always #(CLK_P/2) clk = ~clk;

    ring_dst_wrapper dut_i (
        .clk(clk), .rst(rst), .ring_mode(ring_mode), .ring_base(ring_base),
        .ring_mask(ring_mask), .load_en(load_en), .load_addr(load_addr),
        .burst_en(burst_en), .burst_qwc(burst_qwc), .xfer_done(xfer_done),
        .dst_addr(dst_addr), .ring_warn(ring_warn), .gfx_take(gfx_take),
        .vec_take(vec_take), .take_count(take_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // drive for one cycle, then release; outputs are sampled afterwards
    task automatic cyc(input logic [1:0] m, input logic ld, input logic [31:0] la,
                       input logic b, input logic [15:0] q, input logic d);
        @(negedge clk);
        ring_mode = m; load_en = ld; load_addr = la;
        burst_en = b; burst_qwc = q; xfer_done = d;
        @(negedge clk);
        load_en = 1'b0; burst_en = 1'b0; xfer_done = 1'b0;
    endtask

    // model of one accepted burst, from R2..R5
    task automatic model_burst(input logic [1:0] m, input logic [15:0] q);
        logic [31:0] adv;
        adv = m_addr + ({16'd0, q} << 4);
        if (m[1]) begin
            m_warn = ((m_addr & ~MASK) != BASE);
            m_addr = BASE + (adv & MASK);
            m_acc  = m_acc + {16'd0, q};
        end else begin
            m_warn = 1'b0;
            m_addr = adv;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 addr", dst_addr, 32'h0);
        chk("R1 warn", {31'd0, ring_warn}, 32'h0);
        chk("R1 take", {30'd0, gfx_take, vec_take}, 32'h0);
        chk("R1 count", take_count, 32'h0);
        rst = 1'b0;

        // R8 load
        cyc(2'd2, 1'b1, 32'h0010_0FC0, 1'b0, 16'd0, 1'b0);
        m_addr = 32'h0010_0FC0; m_warn = 1'b0; m_acc = 32'h0;
        chk("R8 load", dst_addr, m_addr);

        // table walk: R2 / R3 / R4 / R5
        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i][17:16], 1'b0, 32'h0, 1'b1, VECS[i][15:0], 1'b0);
            model_burst(VECS[i][17:16], VECS[i][15:0]);
            chk(VECS[i][17] ? "R3 ring addr" : "R2 linear addr", dst_addr, m_addr);
            chk("R4 warn", {31'd0, ring_warn}, {31'd0, m_warn});
        end

        // R6 graphics hand-off carries the ring-only total (R5)
        cyc(2'd3, 1'b0, 32'h0, 1'b0, 16'd0, 1'b1);
        chk("R6 gfx pulse", {30'd0, gfx_take, vec_take}, 32'h2);
        chk("R5 total", take_count, m_acc);
        @(negedge clk);
        chk("R6 single cycle", {30'd0, gfx_take, vec_take}, 32'h0);
        chk("R7 idle count", take_count, 32'h0);
        m_acc = 32'h0;

        // R4 start outside the ring
        cyc(2'd2, 1'b1, 32'h2000_0000, 1'b0, 16'd0, 1'b0);
        m_addr = 32'h2000_0000;
        cyc(2'd2, 1'b0, 32'h0, 1'b1, 16'd1, 1'b0);
        chk("R4 outside warn", {31'd0, ring_warn}, 32'h1);
        chk("R3 pulled in", dst_addr, 32'h0010_0010);
        cyc(2'd2, 1'b0, 32'h0, 1'b1, 16'd1, 1'b0);
        chk("R4 inside clears", {31'd0, ring_warn}, 32'h0);
        chk("R3 next", dst_addr, 32'h0010_0020);
        // R4 warn holds with no burst
        cyc(2'd2, 1'b0, 32'h0, 1'b0, 16'd0, 1'b0);
        chk("R4 hold", {31'd0, ring_warn}, 32'h0);

        // R6 vector hand-off with burst in the same cycle: 1+1+3
        cyc(2'd2, 1'b0, 32'h0, 1'b1, 16'd3, 1'b1);
        chk("R6 vec pulse", {30'd0, gfx_take, vec_take}, 32'h1);
        chk("R6 same-cycle count", take_count, 32'd5);

        // R7 linear completion: no pulse, total kept
        cyc(2'd0, 1'b0, 32'h0, 1'b1, 16'd5, 1'b0);
        cyc(2'd3, 1'b0, 32'h0, 1'b1, 16'd1, 1'b0);
        cyc(2'd1, 1'b0, 32'h0, 1'b0, 16'd0, 1'b1);
        chk("R7 no pulse", {30'd0, gfx_take, vec_take}, 32'h0);
        chk("R7 count zero", take_count, 32'h0);
        cyc(2'd3, 1'b0, 32'h0, 1'b0, 16'd0, 1'b1);
        chk("R7 total kept", take_count, 32'd1);

        // R8 load wins over burst; burst is not counted
        cyc(2'd3, 1'b1, 32'h0010_0100, 1'b1, 16'd7, 1'b0);
        chk("R8 load priority", dst_addr, 32'h0010_0100);
        cyc(2'd3, 1'b0, 32'h0, 1'b0, 16'd0, 1'b1);
        chk("R8 burst dropped", take_count, 32'd0);
        chk("R8 pulse", {30'd0, gfx_take, vec_take}, 32'h2);

        // R1 reset after activity
        cyc(2'd2, 1'b1, 32'h3000_0000, 1'b0, 16'd0, 1'b0);
        cyc(2'd2, 1'b0, 32'h0, 1'b1, 16'd4, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 addr after reset", dst_addr, 32'h0);
        chk("R1 warn after reset", {31'd0, ring_warn}, 32'h0);
        cyc(2'd2, 1'b0, 32'h0, 1'b0, 16'd0, 1'b1);
        chk("R1 total cleared", take_count, 32'h0);

        finish_run();
    end
endmodule